// File: doc/BRIEF.md
# Background Scrub Scheduler

This block keeps a single-error-correcting memory clean by taking over one memory cycle at a time, at an interval the system chooses. A cycle-rate tick of 20 MHz paces every interval. When an interval ends, the block raises an early warning line. After a programmable lead it raises busy and waits until the host reports that it has released the memory. It then reads the word at the current scrub address. Corrected data and its status come back from an external corrector on the next clock. A word with one correctable error is written back at once. A word with an uncorrectable error is flagged and left alone. When correction is bypassed, the block still reads each word but neither writes back nor flags.

The scrub interval is 2^code ticks for a 4-bit rate code, so the rate halves at each step from 20 MHz at code 0. The warning lead is code ticks for a 4-bit lead code, so each step is 50 ns. Busy and the warning are held together until the next tick after the access. They then drop on the same clock, and the scrub address advances by one and wraps to zero.

The controller has seven states:

| State | Behaviour |
|---|---|
| IDLE | Counts the interval. |
| WARN | The warning is up while the lead is counted. |
| GRANT | Busy is up and the block waits for the host. |
| READ | The word is read. |
| CHECK | The corrector status is judged. |
| WRBACK | The corrected word is written back. |
| HOLD | Busy is kept up until the next tick. |

The transitions are:

- IDLE to WARN when the interval expires.
- WARN to GRANT when the lead expires, or on the next clock if the lead code is 0.
- GRANT to READ when the host is idle.
- READ to CHECK always.
- CHECK to WRBACK on a single correctable error with bypass 0.
- CHECK to HOLD otherwise.
- WRBACK to HOLD always.
- HOLD to IDLE on a tick, which also steps the address.

Top module: `scrub_sched`

## Requirements
- R1: While reset is low and on the first clock after it, `warn_o`, `busy_o`, `mem_en_o` and `uncor_o` are 0 and `mem_addr_o` is 0. A reset during a stolen cycle abandons that cycle.
- R2: `warn_o` rises on the clock edge that carries the 2^`rate_code_i`-th tick counted since the block entered IDLE, that is, since reset release or since busy last fell.
- R3: `busy_o` rises `warn_code_i` ticks after `warn_o` rose. With lead code 0 it rises on the next clock. `warn_o` is always already high when `busy_o` rises.
- R4: While busy is up and `host_idle_i` is 0, no memory access is made. The read is issued on the clock after `host_idle_i` is seen high.
- R5: The read (`mem_en_o`=1, `mem_we_o`=0) targets the current scrub address. The corrector outputs are taken on the following clock.
- R6: If the corrector reports a single correctable error (`fix_single_i`=1) and bypass is 0, the corrected word is written (`mem_en_o`=1, `mem_we_o`=1) to the same address on the clock after the status.
- R7: If the corrector reports an uncorrectable word (`fix_double_i`=1) and bypass is 0, `uncor_o` is 1 for exactly the status clock and no write-back follows.
- R8: With `bypass_i`=1 there is never a write-back and `uncor_o` stays 0. The read still happens.
- R9: `busy_o` and `warn_o` stay high from busy rise until the first tick after the access, and both fall on that same edge.
- R10: The scrub address increments by one per completed cycle and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse at the 20 MHz cycle rate |
| rate_code_i | input | CODE_W (4) | Interval code; the interval is 2^code ticks (default 6 at system level) |
| warn_code_i | input | CODE_W (4) | Warning lead in ticks (default 10 at system level) |
| bypass_i | input | 1 | 1 = correction skipped, 0 = normal |
| host_idle_i | input | 1 | Host has released the memory |
| fix_data_i | input | DATA_W (32) | Corrected word from the corrector |
| fix_single_i | input | 1 | Corrector saw one correctable error |
| fix_double_i | input | 1 | Corrector saw an uncorrectable error |
| warn_o | output | 1 | Early warning of a stolen cycle |
| busy_o | output | 1 | Stolen cycle in progress |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W (19) | Scrub address |
| mem_wdata_o | output | DATA_W (32) | Write-back data |
| uncor_o | output | 1 | Uncorrectable word at the current address |

## Verification
The properties take for granted that the corrector never raises the single and double status together. They also assume that the status and bypass are valid on the clock after the read, and that the tick is a one-clock pulse with idle clocks between pulses.

The bench drives the tick as a one-clock pulse every fourth clock. It never sets both status bits in a vector. It changes codes and bypass only while the block is counting its interval, and it presents corrector results only in the clock after a read.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WARN,
        S_GRANT,
        S_READ,
        S_CHECK,
        S_WRBACK,
        S_HOLD
    } scrub_state_e;

endpackage

// File: rtl/scrub_tick_timer.sv
module scrub_tick_timer #(
    parameter int CODE_W = 4,
    parameter bit EXPO   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              done_o
);

    localparam int LIM_W = EXPO ? (1 << CODE_W) + 1 : CODE_W + 1;
    localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt_q;

    generate
        if (EXPO) begin : g_expo
            assign limit = ONE << code_i;
        end else begin : g_lin
            assign limit = LIM_W'(code_i);
        end
    endgenerate

    assign done_o = run_i && ((limit == '0) || (tick_i && (cnt_q == limit - ONE)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || done_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/scrub_addr_ctr.sv
module scrub_addr_ctr #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (step_i) begin
            addr_o <= addr_o + ONE;
        end
    end

endmodule

// File: rtl/scrub_sched.sv
module scrub_sched
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 32,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic [CODE_W-1:0] warn_code_i,
    input  logic              bypass_i,
    input  logic              host_idle_i,
    input  logic [DATA_W-1:0] fix_data_i,
    input  logic              fix_single_i,
    input  logic              fix_double_i,
    output logic              warn_o,
    output logic              busy_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              uncor_o
);

    scrub_state_e state_q, state_d;
    logic         ivl_done, lead_done, addr_step;
    logic [DATA_W-1:0] wdata_q;

    // Interval timer: 2^code ticks while idle
    scrub_tick_timer #(.CODE_W(CODE_W), .EXPO(1'b1)) ivl_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (state_q == S_IDLE),
        .code_i (rate_code_i),
        .done_o (ivl_done)
    );

    // Warning lead timer: code ticks while warning
    scrub_tick_timer #(.CODE_W(CODE_W), .EXPO(1'b0)) lead_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (state_q == S_WARN),
        .code_i (warn_code_i),
        .done_o (lead_done)
    );

    assign addr_step = (state_q == S_HOLD) && tick_i;

    scrub_addr_ctr #(.ADDR_W(ADDR_W)) addr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (addr_step),
        .addr_o (mem_addr_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Corrected word held for write-back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (state_q == S_CHECK && fix_single_i) begin
            wdata_q <= fix_data_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (ivl_done)    state_d = S_WARN;
            S_WARN:   if (lead_done)   state_d = S_GRANT;
            S_GRANT:  if (host_idle_i) state_d = S_READ;
            S_READ:   state_d = S_CHECK;
            S_CHECK: begin
                if (!bypass_i && !fix_double_i && fix_single_i) begin
                    state_d = S_WRBACK;
                end else begin
                    state_d = S_HOLD;
                end
            end
            S_WRBACK: state_d = S_HOLD;
            S_HOLD:   if (tick_i)      state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        warn_o      = 1'b0;
        busy_o      = 1'b0;
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        uncor_o     = 1'b0;
        mem_wdata_o = wdata_q;
        unique case (state_q)
            S_IDLE: ;
            S_WARN:  warn_o = 1'b1;
            S_GRANT: begin
                warn_o = 1'b1;
                busy_o = 1'b1;
            end
            S_READ: begin
                warn_o   = 1'b1;
                busy_o   = 1'b1;
                mem_en_o = 1'b1;
            end
            S_CHECK: begin
                warn_o  = 1'b1;
                busy_o  = 1'b1;
                uncor_o = fix_double_i && !bypass_i;
            end
            S_WRBACK: begin
                warn_o   = 1'b1;
                busy_o   = 1'b1;
                mem_en_o = 1'b1;
                mem_we_o = 1'b1;
            end
            S_HOLD: begin
                warn_o = 1'b1;
                busy_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 32,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              host_idle_i,
    input logic              bypass_i,
    input logic              fix_single_i,
    input logic              warn_o,
    input logic              busy_o,
    input logic              mem_en_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              uncor_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    AST_WARN_LEADS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(warn_o)); // R3
    AST_WARN_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> warn_o); // R9
    AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !warn_o); // R9
    AST_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick_i)); // R9
    AST_MEM_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> busy_o); // R4
    AST_READ_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && !mem_we_o) |-> $past(host_idle_i)); // R4
    AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && mem_we_o) |-> ($past(mem_en_o, 2) && !$past(mem_we_o, 2)
                                    && $past(fix_single_i) && !$past(bypass_i))); // R6
    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && mem_we_o) |-> (mem_addr_o == $past(mem_addr_o, 2))); // R6
    AST_NO_WB_AFTER_UNCOR: assert property (@(posedge clk) disable iff (!rst_n)
        uncor_o |=> !(mem_en_o && mem_we_o)); // R7
    AST_UNCOR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        uncor_o |-> (busy_o && !mem_en_o)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr_o) |-> ((mem_addr_o == $past(mem_addr_o) + ONE)
                                  && $past(busy_o) && !busy_o)); // R10

endmodule

bind scrub_sched scrub_sched_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .host_idle_i  (host_idle_i),
    .bypass_i     (bypass_i),
    .fix_single_i (fix_single_i),
    .warn_o       (warn_o),
    .busy_o       (busy_o),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .uncor_o      (uncor_o)
);

// File: tb/scrub_sched_tb_top.sv
module scrub_sched_tb_top;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int WATCHDOG = 150000;

    typedef struct packed {
        logic [3:0]  rate;
        logic [3:0]  lead;
        logic        byp;
        logic        sgl;
        logic        dbl;
        logic [3:0]  hdly;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 4'd2,  1'b0, 1'b1, 1'b0, 4'd0, 32'hA5A5_0001},
        '{4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd2, 32'h0000_0000},
        '{4'd2, 4'd1,  1'b0, 1'b0, 1'b1, 4'd1, 32'h1234_5678},
        '{4'd3, 4'd3,  1'b1, 1'b1, 1'b0, 4'd0, 32'hDEAD_BEEF},
        '{4'd0, 4'd4,  1'b1, 1'b0, 1'b1, 4'd3, 32'h0F0F_0F0F},
        '{4'd5, 4'd15, 1'b0, 1'b1, 1'b0, 4'd1, 32'hCAFE_F00D},
        '{4'd2, 4'd10, 1'b0, 1'b0, 1'b1, 4'd0, 32'h5555_AAAA},
        '{4'd4, 4'd0,  1'b0, 1'b1, 1'b0, 4'd5, 32'h8000_0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic [CW-1:0] rate_code_i = '0;
    logic [CW-1:0] warn_code_i = '0;
    logic          bypass_i = 1'b0;
    logic          host_idle_i = 1'b0;
    logic [DW-1:0] fix_data_i = '0;
    logic          fix_single_i = 1'b0;
    logic          fix_double_i = 1'b0;
    logic          warn_o, busy_o, mem_en_o, mem_we_o, uncor_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  tcnt = 0;
    int  c0 = 0;
    int  exp_addr = 0;
    int  cyc = 0;
    logic last_tick = 1'b0;

    scrub_sched #(.ADDR_W(AW), .DATA_W(DW), .CODE_W(CW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .rate_code_i  (rate_code_i),
        .warn_code_i  (warn_code_i),
        .bypass_i     (bypass_i),
        .host_idle_i  (host_idle_i),
        .fix_data_i   (fix_data_i),
        .fix_single_i (fix_single_i),
        .fix_double_i (fix_double_i),
        .warn_o       (warn_o),
        .busy_o       (busy_o),
        .mem_en_o     (mem_en_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .uncor_o      (uncor_o)
    );

    always #2 clk = ~clk;

    // Tick: one-clock pulse every fourth clock, driven at negedge
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (tick_i) tcnt <= tcnt + 1;
        last_tick <= tick_i;
        cyc <= cyc + 1;
    end

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One complete stolen cycle; configuration applied while idle
    task automatic run_scrub(input vec_t v);
        int cw;
        bit exp_wr, exp_unc;
        exp_wr  = v.sgl && !v.byp && !v.dbl;
        exp_unc = v.dbl && !v.byp;
        rate_code_i = v.rate;
        warn_code_i = v.lead;
        bypass_i    = v.byp;
        while (!warn_o) @(negedge clk);
        check((tcnt - c0) == (1 << v.rate), "R2", "interval ticks", tcnt - c0, 1 << v.rate);
        check(busy_o == 1'b0, "R3", "busy before warning", busy_o, 0);
        cw = tcnt;
        while (!busy_o) @(negedge clk);
        check((tcnt - cw) == int'(v.lead), "R3", "lead ticks", tcnt - cw, v.lead);
        for (int i = 0; i < int'(v.hdly); i++) begin
            check(mem_en_o == 1'b0, "R4", "access while host busy", mem_en_o, 0);
            @(negedge clk);
        end
        host_idle_i = 1'b1;
        @(negedge clk);
        check(mem_en_o && !mem_we_o, "R4", "read after host idle", {mem_en_o, mem_we_o}, 2);
        check(int'(mem_addr_o) == exp_addr, "R5", "read address", mem_addr_o, exp_addr);
        host_idle_i  = 1'b0;
        fix_data_i   = v.data;
        fix_single_i = v.sgl;
        fix_double_i = v.dbl;
        @(negedge clk);
        check(uncor_o == exp_unc, exp_unc ? "R7" : "R8", "uncorrectable flag", uncor_o, exp_unc);
        @(negedge clk);
        fix_single_i = 1'b0;
        fix_double_i = 1'b0;
        if (exp_wr) begin
            check(mem_en_o && mem_we_o, "R6", "write strobe", {mem_en_o, mem_we_o}, 3);
            check(int'(mem_addr_o) == exp_addr, "R6", "write address", mem_addr_o, exp_addr);
            check(mem_wdata_o == v.data, "R6", "write data", mem_wdata_o, v.data);
        end else begin
            check(mem_en_o == 1'b0, v.byp ? "R8" : "R7", "no write-back", mem_en_o, 0);
        end
        check(uncor_o == 1'b0, "R7", "flag lasts one clock", uncor_o, 0);
        while (busy_o) begin
            check(warn_o == 1'b1, "R9", "warning held in busy", warn_o, 1);
            @(negedge clk);
        end
        check(warn_o == 1'b0, "R9", "warning drops with busy", warn_o, 0);
        check(last_tick == 1'b1, "R9", "busy drops on tick", last_tick, 1);
        c0 = tcnt;
        exp_addr = (exp_addr + 1) % (1 << AW);
        check(int'(mem_addr_o) == exp_addr, "R10", "address step", mem_addr_o, exp_addr);
    endtask

    initial begin
        vec_t wv;
        rate_code_i = 4'd2;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({warn_o, busy_o, mem_en_o, uncor_o} == 4'b0, "R1", "outputs in reset",
              {warn_o, busy_o, mem_en_o, uncor_o}, 0);
        check(mem_addr_o == '0, "R1", "address in reset", mem_addr_o, 0);
        rst_n = 1'b1;
        c0 = tcnt;
        @(negedge clk);
        check({warn_o, busy_o, mem_en_o, uncor_o} == 4'b0, "R1", "outputs after reset",
              {warn_o, busy_o, mem_en_o, uncor_o}, 0);

        foreach (VECS[k]) run_scrub(VECS[k]);

        // R10: walk the address space until it wraps to zero
        wv = '{4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0};
        while (exp_addr != 0) run_scrub(wv);
        check(mem_addr_o == '0, "R10", "wrap to zero", mem_addr_o, 0);
        run_scrub(wv);

        // R1: reset in the middle of a stolen cycle
        rate_code_i = 4'd0;
        warn_code_i = 4'd1;
        while (!busy_o) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check({warn_o, busy_o, mem_en_o, uncor_o} == 4'b0, "R1", "outputs after mid-cycle reset",
              {warn_o, busy_o, mem_en_o, uncor_o}, 0);
        check(mem_addr_o == '0, "R1", "address after mid-cycle reset", mem_addr_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        c0 = tcnt;
        exp_addr = 0;
        wv = '{4'd1, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0, 32'h7777_0000};
        run_scrub(wv);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule